// File: doc/BRIEF.md
# Byte-Handshaked I2C Master Engine

This block is an I2C bus master that software drives one byte at a time through five small byte-wide registers. Software chooses a transfer direction, loads a byte into the data register and writes a go bit. The engine puts a START condition on the bus and shifts the byte out MSB first. It samples the acknowledge slot and then raises a pending flag. While that flag is set the engine holds SCL low, so the bus stays frozen between bytes until software clears the flag.

In master-receive mode the engine shifts a byte in and answers it with ACK or NACK, as the acknowledge-enable bit selects. A STOP condition is requested by writing the go/busy bit as zero. A repeated START is requested by writing that bit as one while the bus is still owned. Each request takes effect when the pending flag is cleared. The SCL rate comes from a two-stage divider: a base of 16 or 512 input clocks times (scale+1). Both bus lines are open-drain. Each output pin pulls its line low and each input pin samples the line through a two-flop synchronizer. A slave that holds SCL low stretches the high phase of the clock.

Top module: `i2cm_master`

## Requirements
- R1: After reset every register reads 0x00, both line pull-downs are released and the interrupt output is low.
- R2: One SCL period equals B*(S+1) input clocks. S is control bits 3:0. B is 16 when control bit 6 is 0 and 512 when it is 1.
- R3: The status register is at offset 0x04 and its fields are: bits 7:6 mode (11 master transmit, 10 master receive, 00 after STOP), bit 5 go/busy, bit 4 output enable. Writing status with bit 5 = 1 while idle issues START and then shifts out the data register (offset 0x0C) MSB first. Status bit 5 then reads 1.
- R4: After each acknowledge slot the engine sets the pending bit (control bit 4, offset 0x00) and holds SCL low until software writes 0 to that bit. The interrupt output equals pending AND control bit 5.
- R5: Status bit 0 holds the SDA level sampled in the last acknowledge slot (1 = NACK).
- R6: In master transmit, each byte written to the data register goes onto the bus MSB first after pending is cleared.
- R7: In master receive, the data register returns the received byte. In the acknowledge slot the engine pulls SDA low when control bit 7 is 1 and releases it when control bit 7 is 0.
- R8: Writing status bit 5 = 0 while busy and then clearing pending produces a STOP. Busy then clears by itself and the mode field returns to 00.
- R9: Writing status bit 5 = 1 while busy and then clearing pending produces a repeated START with no STOP. The data register byte is then transmitted as an address, whatever the mode.
- R10: While paused in master transmit, a data register write pulls SDA to the inverse of the new bit 7 in the very next cycle.
- R11: Writing status bit 4 = 0 releases both lines in the next cycle without a STOP and clears busy and pending.
- R12: A slave holding SCL low delays the engine's clock and the byte still arrives intact.
- R13: Offset 0x08 stores and returns all 8 bits. Offset 0x10 stores and returns its low 3 bits and reads 0 above them. Writing 1 to the pending bit never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq | output | 1 | Interrupt, pending and enabled |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
A wrong phase or bit counter inside the engine shows up on the bus within one byte. The slave model then records a misplaced START or STOP, or a shifted byte, and the pending flag arrives early or late against a byte time of nine SCL periods. A stale direction or acknowledge decision appears in the very next acknowledge slot as a wrong SDA level. That level is visible both to the slave model and in status bit 0. Register and line-release faults are visible one cycle after the offending write.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam logic [4:0] OFS_CTRL = 5'h00;
    localparam logic [4:0] OFS_STAT = 5'h04;
    localparam logic [4:0] OFS_OWN  = 5'h08;
    localparam logic [4:0] OFS_DATA = 5'h0C;
    localparam logic [4:0] OFS_LINE = 5'h10;
    localparam int LINE_W = 3;

    typedef enum logic [2:0] {
        PH_IDLE, PH_START, PH_BITS, PH_HOLD, PH_STOP
    } phase_e;

    typedef struct packed {
        logic       ack_en;
        logic       slow;
        logic       irq_en;
        logic [3:0] scale;
    } ctrl_t;

    function automatic logic [7:0] pack_stat(input logic [1:0] mode, input logic busy,
                                             input logic oe, input logic last);
        return {mode, busy, oe, 3'b000, last};
    endfunction

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], d[i]};
        end
        assign q[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
    parameter int PRE_LO  = 16,
    parameter int PRE_HI  = 512,
    parameter int SCALE_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               slow,
    input  logic [SCALE_W-1:0] scale,
    output logic               tick
);
    localparam int QMAX = (PRE_HI / 4) << SCALE_W;
    localparam int CW   = $clog2(QMAX + 1);

    logic [CW-1:0] cnt, lim;

    always_comb lim = (slow ? CW'(PRE_HI / 4) : CW'(PRE_LO / 4)) * (CW'(scale) + CW'(1)) - CW'(1);

    assign tick = (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst || tick) cnt <= '0;
        else             cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       txen,
    input  logic       stat_wr,
    input  logic       go,
    input  logic       mode_tx,
    input  logic       pend_clr,
    input  logic       ack_en,
    input  logic       data_wr,
    input  logic [7:0] data_in,
    input  logic       scl_s,
    input  logic       sda_s,
    output logic       busy,
    output logic       pend,
    output logic       lastbit,
    output logic [7:0] shreg,
    output logic       scl_drv,
    output logic       sda_drv,
    output logic       stop_done
);
    phase_e     ph;
    logic [1:0] q;
    logic [3:0] bitn;
    logic       first, rs, stop_req, rs_req;
    logic       tx_byte;

    assign tx_byte = first | mode_tx;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= PH_IDLE; q <= '0; bitn <= '0; shreg <= '0;
            first <= 1'b0; rs <= 1'b0; stop_req <= 1'b0; rs_req <= 1'b0;
            busy <= 1'b0; pend <= 1'b0; lastbit <= 1'b0; stop_done <= 1'b0;
        end else begin
            stop_done <= 1'b0;
            if (pend_clr) pend <= 1'b0;
            if (data_wr && (ph == PH_IDLE || ph == PH_HOLD)) shreg <= data_in;
            if (!txen) begin
                ph <= PH_IDLE; q <= '0; busy <= 1'b0; pend <= 1'b0;
                stop_req <= 1'b0; rs_req <= 1'b0;
            end else begin
                if (stat_wr && busy) begin
                    if (go) rs_req <= 1'b1;
                    else    stop_req <= 1'b1;
                end
                case (ph)
                    PH_IDLE: if (stat_wr && go) begin
                        ph <= PH_START; q <= '0; rs <= 1'b0; busy <= 1'b1; pend <= 1'b0;
                    end
                    PH_START: if (tick) begin
                        if (q == 2'd3) begin
                            ph <= PH_BITS; q <= '0; bitn <= '0; first <= 1'b1;
                        end else q <= q + 2'd1;
                    end
                    PH_BITS: if (tick && !(q == 2'd2 && !scl_s)) begin
                        if (q == 2'd3) begin
                            q <= '0;
                            if (bitn == 4'd8) begin
                                lastbit <= sda_s; pend <= 1'b1; ph <= PH_HOLD; bitn <= '0;
                            end else begin
                                shreg <= {shreg[6:0], sda_s}; bitn <= bitn + 4'd1;
                            end
                        end else q <= q + 2'd1;
                    end
                    PH_HOLD: if (!pend) begin
                        q <= '0;
                        if (stop_req) begin
                            ph <= PH_STOP; stop_req <= 1'b0;
                        end else if (rs_req) begin
                            ph <= PH_START; rs <= 1'b1; rs_req <= 1'b0;
                        end else begin
                            ph <= PH_BITS; bitn <= '0; first <= 1'b0;
                        end
                    end
                    PH_STOP: if (tick) begin
                        if (q == 2'd2) begin
                            ph <= PH_IDLE; q <= '0; busy <= 1'b0; stop_done <= 1'b1;
                        end else q <= q + 2'd1;
                    end
                    default: ph <= PH_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        scl_drv = 1'b0;
        sda_drv = 1'b0;
        case (ph)
            PH_START: begin
                scl_drv = (q == 2'd0 && rs) || (q == 2'd3);
                sda_drv = q[1];
            end
            PH_BITS: begin
                scl_drv = !q[1];
                sda_drv = (bitn == 4'd8) ? (!tx_byte && ack_en) : (tx_byte && !shreg[7]);
            end
            PH_HOLD: begin
                scl_drv = 1'b1;
                sda_drv = stop_req || (!rs_req && mode_tx && !shreg[7]);
            end
            PH_STOP: begin
                scl_drv = (q == 2'd0);
                sda_drv = !q[1];
            end
            default: ;
        endcase
    end

    AST_PEND_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(ph == PH_BITS && bitn == 4'd8)); // R4
    AST_BIT_INDEX: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_BITS) |-> (bitn <= 4'd8)); // R6
    AST_HOLD_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_HOLD && $past(ph == PH_HOLD) && !$past(data_wr)) |-> $stable(shreg)); // R10
endmodule

// File: rtl/i2cm_master.sv
module i2cm_master
    import i2cm_pkg::*;
#(
    parameter int PRE_LO  = 16,
    parameter int PRE_HI  = 512,
    parameter int SCALE_W = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [4:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe
);
    ctrl_t             ctrl;
    logic [1:0]        mode;
    logic              txen;
    logic [7:0]        own;
    logic [LINE_W-1:0] linec;
    logic              busy, pend, lastbit, scl_drv, sda_drv, stop_done, tick;
    logic [7:0]        shreg;
    logic [1:0]        synced;
    logic              wr_ctrl, wr_stat, wr_data;

    assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
    assign wr_stat = reg_wr && (reg_addr == OFS_STAT);
    assign wr_data = reg_wr && (reg_addr == OFS_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0; mode <= '0; txen <= 1'b0; own <= '0; linec <= '0;
        end else begin
            if (stop_done) mode <= 2'b00;
            if (wr_ctrl) ctrl <= '{ack_en: reg_wdata[7], slow: reg_wdata[6],
                                   irq_en: reg_wdata[5], scale: reg_wdata[3:0]};
            if (wr_stat) begin
                mode <= reg_wdata[7:6];
                txen <= reg_wdata[4];
            end
            if (reg_wr && reg_addr == OFS_OWN)  own   <= reg_wdata;
            if (reg_wr && reg_addr == OFS_LINE) linec <= reg_wdata[LINE_W-1:0];
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_CTRL: reg_rdata = {ctrl.ack_en, ctrl.slow, ctrl.irq_en, pend, ctrl.scale};
            OFS_STAT: reg_rdata = pack_stat(mode, busy, txen, lastbit);
            OFS_OWN:  reg_rdata = own;
            OFS_DATA: reg_rdata = shreg;
            OFS_LINE: reg_rdata = {{(8-LINE_W){1'b0}}, linec};
            default:  reg_rdata = 8'h00;
        endcase
    end

    i2cm_sync #(.W(2), .STAGES(2)) i_sync (
        .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q(synced)
    );

    i2cm_tick #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .SCALE_W(SCALE_W)) i_tick (
        .clk(clk), .rst(rst), .slow(ctrl.slow), .scale(ctrl.scale), .tick(tick)
    );

    i2cm_engine i_engine (
        .clk(clk), .rst(rst), .tick(tick), .txen(txen),
        .stat_wr(wr_stat), .go(reg_wdata[5]), .mode_tx(mode[0]),
        .pend_clr(wr_ctrl && !reg_wdata[4]), .ack_en(ctrl.ack_en),
        .data_wr(wr_data), .data_in(reg_wdata),
        .scl_s(synced[1]), .sda_s(synced[0]),
        .busy(busy), .pend(pend), .lastbit(lastbit), .shreg(shreg),
        .scl_drv(scl_drv), .sda_drv(sda_drv), .stop_done(stop_done)
    );

    assign scl_oe = txen & scl_drv;
    assign sda_oe = txen & sda_drv;
    assign irq    = pend & ctrl.irq_en;

    AST_PEND_STALLS_SCL: assert property (@(posedge clk) disable iff (rst)
        (pend && busy && txen) |-> scl_oe); // R4
    AST_OE_DROP_FREES: assert property (@(posedge clk) disable iff (rst)
        !txen |=> !busy); // R11
endmodule

// File: tb/test_i2cm_master.sv
module test_i2cm_master;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [4:0] reg_addr = 5'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq, scl_oe, sda_oe;
    logic       scl_b, sda_b;

    int total = 0;
    int fails = 0;

    // slave model state
    logic       sl_scl_low = 1'b0, sl_sda_low = 1'b0;
    logic       pscl = 1'b1, psda = 1'b1;
    logic [7:0] ssh = 8'h00, rx_byte = 8'h00, txb = 8'h00;
    logic       mack = 1'b0, addr_ph = 1'b0, sl_tx = 1'b0, sl_nack = 1'b0, stretch_arm = 1'b0;
    int         bitc = 0, starts = 0, stops = 0, hold_cnt = 0, sl_idx = 0;
    logic [7:0] sl_data [8];

    localparam logic [6:0] SLV = 7'h2C;

    always #4 clk = ~clk;

    assign scl_b = !(scl_oe || sl_scl_low);
    assign sda_b = !(sda_oe || sl_sda_low);

    i2cm_master i_i2cm_master (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_in(scl_b), .sda_in(sda_b), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    always @(posedge clk) begin
        pscl <= scl_b;
        psda <= sda_b;
        if (hold_cnt != 0) hold_cnt <= hold_cnt - 1;
        sl_scl_low <= (hold_cnt > 1);
        if (pscl && scl_b && psda && !sda_b) begin
            starts <= starts + 1; bitc <= 0; addr_ph <= 1'b1; sl_tx <= 1'b0; sl_sda_low <= 1'b0;
        end else if (pscl && scl_b && !psda && sda_b) begin
            stops <= stops + 1; sl_sda_low <= 1'b0; sl_tx <= 1'b0;
        end else if (!pscl && scl_b) begin
            if (bitc < 8) ssh <= {ssh[6:0], sda_b};
            else          mack <= sda_b;
            bitc <= bitc + 1;
        end else if (pscl && !scl_b) begin
            if (stretch_arm && bitc == 3) begin hold_cnt <= 200; stretch_arm <= 1'b0; end
            if (bitc == 8) begin
                if (addr_ph || !sl_tx) begin
                    rx_byte <= ssh; sl_sda_low <= !sl_nack;
                    if (addr_ph) begin sl_tx <= ssh[0]; addr_ph <= 1'b0; end
                end else sl_sda_low <= 1'b0;
            end else if (bitc == 9) begin
                bitc <= 0;
                if (sl_tx && !mack) begin
                    txb <= sl_data[sl_idx]; sl_sda_low <= !sl_data[sl_idx][7]; sl_idx <= sl_idx + 1;
                end else begin
                    sl_sda_low <= 1'b0; sl_tx <= 1'b0;
                end
            end else if (sl_tx && !addr_ph && bitc >= 1 && bitc <= 7) begin
                sl_sda_low <= !txb[7-bitc];
            end
        end
    end

    function automatic logic [7:0] exp_stat(input logic [1:0] m, input logic b, input logic o, input logic l);
        return {m, b, o, 3'b000, l};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic wait_pend(output int cyc);
        cyc = -1;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (irq) begin cyc = i + 1; break; end
        end
        if (cyc < 0) chk(0, "R4 pending never set", 0, 1);
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 2000; i++) begin
            rd(5'h04, s);
            if (!s[5]) return;
        end
        chk(0, "R8 busy never cleared", 1, 0);
    endtask

    task automatic measure(output int per);
        logic p;
        per = 0;
        p = scl_b;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (scl_b && !p) break;
            p = scl_b;
        end
        p = scl_b;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk); per++;
            if (scl_b && !p) break;
            p = scl_b;
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        finish_up();
    end

    initial begin
        logic [7:0] r, b;
        logic [7:0] tx [4];
        int cyc, t0, t1, per, s0, p0;

        void'($urandom(32'd2024));
        for (int i = 0; i < 4; i++) tx[i] = 8'($urandom());
        for (int i = 0; i < 8; i++) sl_data[i] = 8'($urandom());

        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(5'h00, r); chk(r == 8'h00, "R1 control", r, 0);
        rd(5'h04, r); chk(r == 8'h00, "R1 status", r, 0);
        chk(!scl_oe && !sda_oe && !irq, "R1 lines and irq", {scl_oe, sda_oe, irq}, 0);

        // R13 storage registers and ignored pending set
        wr(5'h08, 8'h5A); rd(5'h08, r); chk(r == 8'h5A, "R13 own address", r, 8'h5A);
        wr(5'h10, 8'hFF); rd(5'h10, r); chk(r == 8'h07, "R13 line control", r, 8'h07);
        wr(5'h00, 8'h30); rd(5'h00, r); chk(r == 8'h20, "R13 pending write ignored", r, 8'h20);

        // write transfer, scale 0
        wr(5'h00, 8'hA0);
        wr(5'h04, 8'hD0);
        wr(5'h0C, {SLV, 1'b0});
        s0 = starts;
        wr(5'h04, 8'hF0);
        measure(per); chk(per == 16, "R2 period base 16 scale 0", per, 16);
        wait_pend(cyc);
        chk(starts == s0 + 1 && rx_byte == {SLV, 1'b0}, "R3 start and address", rx_byte, {SLV, 1'b0});
        rd(5'h04, r); chk(r == exp_stat(2'b11, 1, 1, 0), "R3 R5 status after ack", r, exp_stat(2'b11, 1, 1, 0));
        p0 = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (scl_b) p0++; end
        chk(p0 == 0 && irq, "R4 SCL held while pending", p0, 0);

        for (int i = 0; i < 4; i++) begin
            if (i == 2) stretch_arm = 1'b1;
            if (i == 3) sl_nack = 1'b1;
            wr(5'h0C, tx[i]);
            chk(sda_oe == !tx[i][7], "R10 first bit immediate", sda_oe, !tx[i][7]);
            wr(5'h00, 8'hA0);
            chk(!irq, "R4 clear pending", irq, 0);
            wait_pend(cyc);
            if (i == 1) t0 = cyc;
            if (i == 2) begin
                t1 = cyc;
                chk(t1 >= t0 + 150, "R12 stretch delays byte", t1, t0 + 150);
            end
            chk(rx_byte == tx[i], "R6 R12 transmitted byte", rx_byte, tx[i]);
        end
        rd(5'h04, r); chk(r[0] == 1'b1, "R5 NACK seen", r[0], 1);
        sl_nack = 1'b0;
        p0 = stops;
        wr(5'h04, 8'hD0);
        wr(5'h00, 8'hA0);
        wait_idle();
        chk(stops == p0 + 1, "R8 stop issued", stops, p0 + 1);
        rd(5'h04, r); chk(r == exp_stat(2'b00, 0, 1, 1), "R8 status after stop", r, exp_stat(2'b00, 0, 1, 1));

        // write pointer then repeated start into read
        wr(5'h04, 8'hD0);
        wr(5'h0C, {SLV, 1'b0});
        wr(5'h04, 8'hF0);
        wait_pend(cyc);
        wr(5'h0C, 8'h33); wr(5'h00, 8'hA0); wait_pend(cyc);
        chk(rx_byte == 8'h33, "R6 pointer byte", rx_byte, 8'h33);
        s0 = starts; p0 = stops; sl_idx = 0;
        wr(5'h04, 8'hB0);
        wr(5'h0C, {SLV, 1'b1});
        wr(5'h00, 8'hA0);
        wait_pend(cyc);
        chk(starts == s0 + 1 && stops == p0, "R9 repeated start without stop", starts - s0, 1);
        chk(rx_byte == {SLV, 1'b1}, "R9 address after restart", rx_byte, {SLV, 1'b1});
        for (int i = 0; i < 3; i++) begin
            wr(5'h00, (i == 2) ? 8'h20 : 8'hA0);
            wait_pend(cyc);
            rd(5'h0C, r); chk(r == sl_data[i], "R7 received byte", r, sl_data[i]);
            chk(mack == (i == 2), "R7 acknowledge response", mack, (i == 2));
        end
        wr(5'h04, 8'h90);
        wr(5'h00, 8'h20);
        wait_idle();
        chk(stops == p0 + 1, "R8 stop after read", stops, p0 + 1);

        // scale 1, then abort by output enable
        wr(5'h00, 8'hA1);
        wr(5'h04, 8'hD0);
        wr(5'h0C, {SLV, 1'b0});
        wr(5'h04, 8'hF0);
        measure(per); chk(per == 32, "R2 period base 16 scale 1", per, 32);
        wait_pend(cyc);
        p0 = stops;
        wr(5'h04, 8'hC0);
        chk(!scl_oe && !sda_oe, "R11 lines released", {scl_oe, sda_oe}, 0);
        rd(5'h04, r); chk(r[5] == 1'b0, "R11 busy cleared", r[5], 0);
        rd(5'h00, r); chk(r[4] == 1'b0, "R11 pending cleared", r[4], 0);
        repeat (20) @(negedge clk);
        chk(stops == p0, "R11 no stop produced", stops, p0);

        // slow base
        wr(5'h00, 8'hE0);
        wr(5'h04, 8'hD0);
        wr(5'h0C, {SLV, 1'b0});
        wr(5'h04, 8'hF0);
        measure(per); chk(per == 512, "R2 period base 512", per, 512);
        wait_pend(cyc);
        b = rx_byte; chk(b == {SLV, 1'b0}, "R3 slow address", b, {SLV, 1'b0});
        wr(5'h04, 8'hD0);
        wr(5'h00, 8'hE0);
        wait_idle();

        finish_up();
    end
endmodule